// File: doc/BRIEF.md
# Zero-turnaround synchronous SRAM with flow-through reads

This block is a synthesizable model of a single-port synchronous SRAM whose bus never needs an idle cycle when it switches between reads and writes. Address and control are registered on a rising clock edge, and the data phase of that operation, read or write, happens in the next cycle. Reads are flow-through: the word at the registered address comes straight from the array during the data cycle, with no output register in the path.

An active-low clock enable freezes the whole device, including a data phase that is already pending. An active-low chip select stops new operations from starting, but an operation issued in the previous cycle still completes. The output enable acts asynchronously on the drive enable. The bidirectional data bus is split into a write-data input, a read-data output and a drive-enable output. The word width and the address width are parameters. The default is 1K x 8, and widening the address to 17 bits gives the full 128K x 8 organisation. Array contents are not cleared at reset.

Top module: `zbt_sram`

## Requirements
- R1: On a rising edge where clk_en_ni and sel_ni are both low, addr_i and wr_ni are captured and a new operation starts. Otherwise no operation is started.
- R2: A captured wr_ni of 0 starts a write and a captured wr_ni of 1 starts a read, both at the captured address.
- R3: The data phase is the cycle after the capturing edge. Read data is presented on rdata_o during that cycle. Write data is taken from wdata_i at the rising edge that ends that cycle.
- R4: Reads and writes can be issued on consecutive cycles in any order, with no idle cycle between them.
- R5: While clk_en_ni is sampled high, every other synchronous input is ignored and no array write happens. rdata_o and drive_o stay unchanged, and a pending data phase waits for the next edge at which clk_en_ni is low.
- R6: When sel_ni is sampled high with clk_en_ni low, no operation starts. The operation from the previous cycle still completes, and drive_o is low in the cycle that follows.
- R7: oe_ni acts without waiting for a clock edge. While oe_ni is high, drive_o is low. oe_ni has no effect on writes.
- R8: During a read data phase, rdata_o equals the array word at the registered address, with no further register stage.
- R9: A read issued in the cycle right after a write to the same address returns the newly written data.
- R10: After reset no operation is pending and drive_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low; high freezes the device |
| sel_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | 0 = write, 1 = read |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data, sampled in the data phase |
| rdata_o | output | DATA_W | Flow-through read data |
| drive_o | output | 1 | Bus drive enable for rdata_o |

## Verification
The bench builds the block with ADDR_W=6 and DATA_W=8. The array then has only 64 words, so random traffic keeps returning to the same addresses. This makes read-after-write collisions and overwrites of earlier data common. It also means that writes blocked by a freeze or a deselect show up in later reads of the same word.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RD   = 2'd1,
    PH_WR   = 2'd2
  } ph_op_e;
endpackage

// File: rtl/zbt_sram_ctrl.sv
module zbt_sram_ctrl
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_ni,
  input  logic              sel_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output ph_op_e            op_o,
  output logic [ADDR_W-1:0] addr_o
);
  ph_op_e            op_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= PH_IDLE;
      addr_q <= '0;
    end else if (!clk_en_ni) begin
      if (!sel_ni) begin
        op_q   <= wr_ni ? PH_RD : PH_WR;
        addr_q <= addr_i;
      end else begin
        op_q   <= PH_IDLE;
      end
    end
  end

  assign op_o   = op_q;
  assign addr_o = addr_q;

  assert_freeze_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_ni |=> ($stable(op_q) && $stable(addr_q)));
  assert_deselect_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && sel_ni) |=> (op_q == PH_IDLE));
  assert_capture_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !sel_ni && !wr_ni) |=> (op_q == PH_WR && addr_q == $past(addr_i)));
  assert_capture_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !sel_ni && wr_ni) |=> (op_q == PH_RD && addr_q == $past(addr_i)));
endmodule

// File: rtl/zbt_sram_array.sv
module zbt_sram_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // no reset: contents undefined after power-up
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  // flow-through read
  assign rdata_o = mem_q[addr_i];

  assert_write_commit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(addr_i)] == $past(wdata_i)));
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_ni,
  input  logic              sel_ni,
  input  logic              wr_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  ph_op_e            ph_op;
  logic [ADDR_W-1:0] ph_addr;
  logic              arr_we;

  zbt_sram_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clk_en_ni(clk_en_ni),
    .sel_ni   (sel_ni),
    .wr_ni    (wr_ni),
    .addr_i   (addr_i),
    .op_o     (ph_op),
    .addr_o   (ph_addr)
  );

  // a write commits only at an edge that is not frozen
  assign arr_we = (ph_op == PH_WR) && !clk_en_ni;

  zbt_sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (arr_we),
    .addr_i (ph_addr),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o)
  );

  assign drive_o = (ph_op == PH_RD) && !oe_ni;

  assert_oe_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_o);
  assert_frozen_output_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_ni && $past(clk_en_ni) && $stable(oe_ni)) |-> ($stable(rdata_o) && $stable(drive_o)));
endmodule

// File: tb/zbt_sram_tb_top.sv
`timescale 1ns/1ps
module zbt_sram_tb_top;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          clk_en_ni = 1'b0, sel_ni = 1'b1, wr_ni = 1'b1, oe_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          drive_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [DW-1:0] ref_mem [NW];
  int            pend_op = 0;   // 0 idle, 1 read, 2 write
  logic [AW-1:0] pend_addr = '0;

  always #2.5 clk = ~clk;

  zbt_sram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .clk_en_ni(clk_en_ni), .sel_ni(sel_ni),
    .wr_ni(wr_ni), .oe_ni(oe_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .drive_o(drive_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_drive(input bit oe_n);
    return (pend_op == 1) && !oe_n;
  endfunction

  task automatic cyc(input bit cen_n, input bit cs_n, input bit we_n, input bit oe_n,
                     input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    clk_en_ni = cen_n; sel_ni = cs_n; wr_ni = we_n; oe_ni = oe_n;
    addr_i = a; wdata_i = d;
    #1;
    check({31'd0, drive_o}, {31'd0, exp_drive(oe_n)}, tag);
    if (pend_op == 1) check({24'd0, rdata_o}, {24'd0, ref_mem[pend_addr]}, tag);
    @(posedge clk);
    if (!cen_n) begin
      if (pend_op == 2) ref_mem[pend_addr] = d;
      if (!cs_n) begin
        pend_op   = we_n ? 1 : 2;
        pend_addr = a;
      end else begin
        pend_op = 0;
      end
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #1;
    check({31'd0, drive_o}, 32'd0, "R10 reset drive");
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    check({31'd0, drive_o}, 32'd0, "R10 after reset");

    // fill array, back-to-back writes
    for (int i = 0; i < NW; i++) cyc(0, 0, 0, 0, i[AW-1:0], 8'(i * 7 + 3), "R2 fill");
    cyc(0, 1, 1, 0, '0, 8'h00, "R3 last write data");

    // read sweep, flow-through
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0, i[AW-1:0], 8'hEE, "R8 read");

    // alternating write/read to same address
    for (int i = 0; i < 6; i++) begin
      cyc(0, 0, 0, 0, 6'd10, 8'h11, "R4 wr");
      cyc(0, 0, 1, 0, 6'd10, 8'(8'h40 + i), "R9 raw");
    end
    cyc(0, 0, 1, 0, 6'd10, 8'h00, "R9 raw data");

    // freeze during pending read and pending write
    cyc(0, 0, 1, 0, 6'd20, 8'h00, "R5 issue rd");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 6'd21, 8'hA5, "R5 frozen rd");
    cyc(0, 0, 0, 0, 6'd22, 8'h5A, "R5 issue wr");
    for (int i = 0; i < 2; i++) cyc(1, 0, 1, 0, 6'd23, 8'hFF, "R5 frozen wr");
    cyc(0, 0, 1, 0, 6'd22, 8'h77, "R5 wr commit");
    cyc(0, 0, 1, 0, 6'd21, 8'h00, "R5 no junk wr");
    cyc(0, 1, 1, 0, '0, 8'h00, "R5 readback");

    // deselect: in-flight op completes, bus released next cycle
    cyc(0, 0, 1, 0, 6'd30, 8'h00, "R6 issue rd");
    cyc(0, 1, 0, 0, 6'd31, 8'h99, "R6 rd completes");
    cyc(0, 1, 0, 0, 6'd31, 8'h99, "R6 released");
    cyc(0, 0, 0, 0, 6'd32, 8'h00, "R6 issue wr");
    cyc(0, 1, 0, 0, 6'd33, 8'hC3, "R6 wr completes");
    cyc(0, 0, 1, 0, 6'd32, 8'h00, "R1 cs blocked");
    cyc(0, 0, 1, 0, 6'd33, 8'h00, "R1 read 32");
    cyc(0, 1, 1, 0, '0, 8'h00, "R1 read 33");

    // oe asynchronous, and ignored on writes
    cyc(0, 0, 1, 0, 6'd40, 8'h00, "R7 issue rd");
    #1; oe_ni = 1'b1; #0.5;
    check({31'd0, drive_o}, 32'd0, "R7 oe high off");
    oe_ni = 1'b0; #0.5;
    check({31'd0, drive_o}, 32'd1, "R7 oe low on");
    check({24'd0, rdata_o}, {24'd0, ref_mem[6'd40]}, "R7 oe data");
    cyc(0, 0, 0, 1, 6'd41, 8'h00, "R7 rd oe high");
    cyc(0, 0, 1, 1, 6'd41, 8'hD2, "R7 wr oe high");
    cyc(0, 1, 1, 0, '0, 8'h00, "R7 wr landed");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 5) == 0, ($urandom % 7) == 0, $urandom % 2, ($urandom % 10) == 0,
          AW'($urandom), DW'($urandom), "R4 random");
    end
    cyc(0, 1, 1, 0, '0, 8'h00, "R3 drain");
    cyc(0, 1, 1, 0, '0, 8'h00, "R6 idle");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule